// File: doc/BRIEF.md
# Cascaded Priority Interrupt Controller with Per-Line Trigger Select

This block pairs two eight-line fixed-priority interrupt controllers, a primary and a secondary, to serve sixteen request lines. The secondary's interrupt output drives the primary's cascade line, number 2. A host configures both controllers through a byte-wide I/O port bus. Each controller has a command port and a data port. Two extra ports hold per-line trigger-select registers: a bit of 0 makes a line edge-triggered and a bit of 1 makes it level-triggered. The block raises `intr` when an unmasked request outranks everything in service. The host answers with an acknowledge and gets back an interrupt vector. The host retires an in-service line with a specific or non-specific end-of-interrupt command.

The acknowledge and the vector form a valid/ready stream. An acknowledge is taken on a cycle where `ack_valid` and `ack_ready` are both high. The vector appears with `vec_valid` on the next cycle. It stays unchanged until the host takes it with `vec_ready`, and `ack_ready` stays low for that whole time. An acknowledge offered while a vector is still waiting is not taken and changes nothing. The I/O bus has no back-pressure: reads return data in the same cycle and writes take effect at the clock edge.

Top module: `casc_irq_ctrl`

## Requirements
- R1: After reset, every request, in-service, mask and trigger-select bit is 0, `intr` and `vec_valid` are low, and `ack_ready` is high.
- R2: A write to port 0x4D0 stores data AND 0xF8 in the primary trigger-select register. A write to port 0x4D1 stores data AND 0xDE in the secondary one. Reading either port returns the stored value.
- R3: An access to any of the six ports (0x20, 0x21, 0xA0, 0xA1, 0x4D0, 0x4D1) whose `io_size` is not 1 raises `io_err` in that cycle. A rejected write changes nothing, and a rejected read returns 0.
- R4: A command-port write with bit 4 = 1 is an initialization word. It clears the mask and in-service registers and starts a sequence of data-port writes: the vector base comes first, then a cascade word if bit 1 was 0, then a mode word if bit 0 was 1. Data writes after the sequence set the mask. A command write with bits 4:3 = 01 is a read-select word: bits 1:0 = 10 make command-port reads return the request register, and 11 make them return the in-service register. The data port always reads back the mask.
- R5: An edge-mode request bit is set one cycle after its line goes from 0 to 1. It stays set until that line is acknowledged, even while the input stays high.
- R6: A level-mode request bit follows the input line a cycle later. Acknowledging a level-mode line leaves its request bit set.
- R7: `intr` is high exactly when some unmasked request has a lower line number than the lowest in-service bit, or when any unmasked request is pending while nothing is in service. Line 0 has the highest priority, and masked lines never raise `intr`.
- R8: For a primary line other than 2, the vector is the line number plus the primary base. When line 2 wins, the secondary's best line is acknowledged as well, and the vector is that line's number (0 to 7) plus the secondary base. An acknowledge sets the in-service bit of every acknowledged line.
- R9: A command write with bits 7:5 = 011 and bits 4:3 = 00 is a specific end-of-interrupt. It clears the in-service bit named by bits 2:0.
- R10: A command write with bits 7:5 = 001 and bits 4:3 = 00 is a non-specific end-of-interrupt. It clears the lowest-numbered in-service bit.
- R11: The vector appears one cycle after the acknowledge is accepted. It is held stable with `ack_ready` low until `vec_ready` takes it, and an acknowledge offered during the hold is ignored.
- R12: An acknowledge taken while `intr` is low returns the primary base plus 7 and changes no register.
- R13: When an acknowledge and an end-of-interrupt reach the same controller in one cycle, both take effect. The end-of-interrupt works on the in-service bits as they stood before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq | input | 16 | Request lines: 7:0 to the primary, 15:8 to the secondary. Bit 2 is ORed with the secondary's interrupt |
| io_addr | input | 16 | I/O port address |
| io_size | input | 3 | Access width in bytes |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid in the same cycle as `io_rd` |
| io_err | output | 1 | Access rejected because of its width |
| intr | output | 1 | Interrupt request to the host |
| ack_valid | input | 1 | Acknowledge offered |
| ack_ready | output | 1 | Acknowledge can be accepted |
| vec_valid | output | 1 | Vector available |
| vec_ready | input | 1 | Host takes the vector |
| vec | output | 8 | Interrupt vector |

## Verification
Two things can hit the in-service register of one controller in the same cycle: an acknowledge that sets a bit and an end-of-interrupt command that clears one. The bench forces this by raising `ack_valid` and a command-port write on the same clock edge. It does this once with a specific end-of-interrupt and once with a non-specific one. It then reads the in-service register back through the read-select word, checks that the new bit was set, and checks that the bit cleared is the one chosen from the register's earlier contents.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int PIC_LINES = 8;
  localparam int PIC_IDX_W = $clog2(PIC_LINES);

  typedef logic [PIC_LINES-1:0] line_vec_t;
  typedef logic [PIC_IDX_W-1:0] line_idx_t;

  // write strobes steered to one controller
  typedef struct packed {
    logic cmd_wr;
    logic dat_wr;
    logic trg_wr;
  } wr_sel_t;

  // read selects steered to one controller
  typedef struct packed {
    logic cmd_rd;
    logic dat_rd;
    logic trg_rd;
  } rd_sel_t;

  typedef enum logic [1:0] {
    SEQ_RUN,
    SEQ_BASE,
    SEQ_CASC,
    SEQ_MODE
  } init_seq_t;

  // index of the lowest set bit; 0 when none are set
  function automatic line_idx_t lowest_set(input line_vec_t v);
    line_idx_t r;
    r = '0;
    for (int i = PIC_LINES - 1; i >= 0; i--) begin
      if (v[i]) r = line_idx_t'(i);
    end
    return r;
  endfunction

  function automatic line_vec_t idx_onehot(input line_idx_t i);
    return line_vec_t'(1) << i;
  endfunction
endpackage

// File: rtl/pic_port_map.sv
module pic_port_map
  import pic_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SIZE_W = 3,
  parameter logic [ADDR_W-1:0] P_CMD_ADDR = 16'h0020,
  parameter logic [ADDR_W-1:0] P_DAT_ADDR = 16'h0021,
  parameter logic [ADDR_W-1:0] S_CMD_ADDR = 16'h00A0,
  parameter logic [ADDR_W-1:0] S_DAT_ADDR = 16'h00A1,
  parameter logic [ADDR_W-1:0] P_TRG_ADDR = 16'h04D0,
  parameter logic [ADDR_W-1:0] S_TRG_ADDR = 16'h04D1
) (
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [SIZE_W-1:0] io_size,
  input  logic              io_wr,
  input  logic              io_rd,
  output wr_sel_t [1:0]     wsel,
  output rd_sel_t [1:0]     rsel,
  output logic              acc_err
);
  localparam int UNITS = 2;

  logic [UNITS-1:0] hit_cmd, hit_dat, hit_trg;
  logic size_ok, any_hit;

  assign hit_cmd = {io_addr == S_CMD_ADDR, io_addr == P_CMD_ADDR};
  assign hit_dat = {io_addr == S_DAT_ADDR, io_addr == P_DAT_ADDR};
  assign hit_trg = {io_addr == S_TRG_ADDR, io_addr == P_TRG_ADDR};

  assign size_ok = (io_size == SIZE_W'(1));
  assign any_hit = |{hit_cmd, hit_dat, hit_trg};
  assign acc_err = (io_wr | io_rd) & any_hit & ~size_ok;

  for (genvar g = 0; g < UNITS; g++) begin : g_sel
    wr_sel_t w;
    rd_sel_t r;
    always_comb begin
      w.cmd_wr = io_wr & size_ok & hit_cmd[g];
      w.dat_wr = io_wr & size_ok & hit_dat[g];
      w.trg_wr = io_wr & size_ok & hit_trg[g];
      r.cmd_rd = io_rd & size_ok & hit_cmd[g];
      r.dat_rd = io_rd & size_ok & hit_dat[g];
      r.trg_rd = io_rd & size_ok & hit_trg[g];
    end
    assign wsel[g] = w;
    assign rsel[g] = r;
  end
endmodule

// File: rtl/pic_unit.sv
module pic_unit
  import pic_pkg::*;
#(
  parameter line_vec_t TRG_MASK = '1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  line_vec_t irq_in,
  input  wr_sel_t   sel,
  input  logic [7:0] wdata,
  input  logic      ack_en,
  input  line_idx_t ack_line,
  output logic      int_out,
  output line_idx_t best_line,
  output logic [7:0] base,
  output logic [7:0] cmd_rdata,
  output line_vec_t imr_o,
  output line_vec_t trg_o
);
  line_vec_t irr, isr, imr, trg, irq_q;
  line_vec_t rise, irr_nx, eoi_clr, ack_set, ack_clr, pend;
  logic [7:0] base_q;
  init_seq_t seq;
  logic want_casc, want_mode, show_isr;
  logic is_init, is_eoi_cmd, is_rsel, eoi_on, eoi_spec;

  // command classification
  assign is_init    = sel.cmd_wr & wdata[4];
  assign is_eoi_cmd = sel.cmd_wr & (wdata[4:3] == 2'b00);
  assign is_rsel    = sel.cmd_wr & (wdata[4:3] == 2'b01);
  assign eoi_on     = is_eoi_cmd & wdata[5] & ~wdata[7];
  assign eoi_spec   = eoi_on & wdata[6];

  always_comb begin
    eoi_clr = '0;
    if (eoi_spec)            eoi_clr = idx_onehot(wdata[PIC_IDX_W-1:0]);
    else if (eoi_on && |isr) eoi_clr = idx_onehot(lowest_set(isr));
  end

  assign ack_set = ack_en ? idx_onehot(ack_line) : '0;
  assign ack_clr = ack_set & ~trg;
  assign rise    = irq_in & ~irq_q;

  // level lines track the pin; edge lines latch rises until acknowledged
  for (genvar i = 0; i < PIC_LINES; i++) begin : g_req
    assign irr_nx[i] = trg[i] ? irq_in[i] : ((irr[i] & ~ack_clr[i]) | rise[i]);
  end

  assign pend      = irr & ~imr;
  assign best_line = lowest_set(pend);
  assign int_out   = (|pend) & (~(|isr) | (lowest_set(pend) < lowest_set(isr)));

  assign base      = base_q;
  assign cmd_rdata = show_isr ? isr : irr;
  assign imr_o     = imr;
  assign trg_o     = trg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q     <= '0;
      irr       <= '0;
      isr       <= '0;
      imr       <= '0;
      trg       <= '0;
      base_q    <= '0;
      seq       <= SEQ_RUN;
      want_casc <= 1'b0;
      want_mode <= 1'b0;
      show_isr  <= 1'b0;
    end else begin
      irq_q <= irq_in;
      irr   <= irr_nx;
      if (sel.trg_wr) trg <= wdata & TRG_MASK;
      if (is_init) begin
        isr       <= '0;
        imr       <= '0;
        show_isr  <= 1'b0;
        want_casc <= ~wdata[1];
        want_mode <= wdata[0];
        seq       <= SEQ_BASE;
      end else begin
        isr <= (isr & ~eoi_clr) | ack_set;
        if (is_rsel && wdata[1]) show_isr <= wdata[0];
        if (sel.dat_wr) begin
          unique case (seq)
            SEQ_BASE: begin
              base_q <= wdata;
              seq    <= want_casc ? SEQ_CASC : (want_mode ? SEQ_MODE : SEQ_RUN);
            end
            SEQ_CASC: seq <= want_mode ? SEQ_MODE : SEQ_RUN;
            SEQ_MODE: seq <= SEQ_RUN;
            SEQ_RUN:  imr <= wdata;
          endcase
        end
      end
    end
  end

  AST_TRG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    sel.trg_wr |=> (trg_o == ($past(wdata) & TRG_MASK))); // R2

  AST_EDGE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_in & ~irq_q & ~trg) != '0) |=>
      ((irr & $past(irq_in & ~irq_q & ~trg)) == $past(irq_in & ~irq_q & ~trg))); // R5

  AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_en && trg[ack_line] && irq_in[ack_line]) |=> irr[$past(ack_line)]); // R6

  AST_SPEC_EOI: assert property (@(posedge clk) disable iff (!rst_n)
    (sel.cmd_wr && wdata[7:3] == 5'b01100 && !ack_en) |=> !isr[$past(wdata[2:0])]); // R9

  AST_INIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (sel.cmd_wr && wdata[4]) |=> (isr == '0 && imr_o == '0)); // R4
endmodule

// File: rtl/pic_ack_path.sv
module pic_ack_path
  import pic_pkg::*;
#(
  parameter int VEC_W     = 8,
  parameter int CASC_LINE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack_valid,
  output logic             ack_ready,
  output logic             vec_valid,
  input  logic             vec_ready,
  output logic [VEC_W-1:0] vec,
  input  logic             p_int,
  input  line_idx_t        p_line,
  input  logic [VEC_W-1:0] p_base,
  input  logic             s_int,
  input  line_idx_t        s_line,
  input  logic [VEC_W-1:0] s_base,
  output logic             p_ack,
  output line_idx_t        p_ack_line,
  output logic             s_ack,
  output line_idx_t        s_ack_line
);
  localparam line_idx_t CASC = line_idx_t'(CASC_LINE);
  localparam line_idx_t SPUR = '1;

  logic vld_q, fire, to_sec;
  logic [VEC_W-1:0] vec_q, vec_nx;

  assign ack_ready  = ~vld_q;
  assign fire       = ack_valid & ~vld_q;
  assign to_sec     = p_int & (p_line == CASC);
  assign p_ack      = fire & p_int;
  assign p_ack_line = p_line;
  assign s_ack      = fire & to_sec & s_int;
  assign s_ack_line = s_line;

  always_comb begin
    if (!p_int)      vec_nx = p_base + VEC_W'(SPUR);
    else if (!to_sec) vec_nx = p_base + VEC_W'(p_line);
    else if (s_int)  vec_nx = s_base + VEC_W'(s_line);
    else             vec_nx = s_base + VEC_W'(SPUR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      vec_q <= '0;
    end else begin
      vld_q <= fire | (vld_q & ~vec_ready);
      if (fire) vec_q <= vec_nx;
    end
  end

  assign vec_valid = vld_q;
  assign vec       = vec_q;

  AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !vec_ready) |=> (vec_valid && $stable(vec))); // R11

  AST_ACK_TO_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_ready) |=> vec_valid); // R11
endmodule

// File: rtl/casc_irq_ctrl.sv
module casc_irq_ctrl
  import pic_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SIZE_W = 3,
  parameter int VEC_W  = 8,
  parameter int CASC_LINE = 2,
  parameter line_vec_t P_TRG_MASK = 8'hF8,
  parameter line_vec_t S_TRG_MASK = 8'hDE
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [2*PIC_LINES-1:0] irq,
  input  logic [ADDR_W-1:0]      io_addr,
  input  logic [SIZE_W-1:0]      io_size,
  input  logic                   io_wr,
  input  logic                   io_rd,
  input  logic [7:0]             io_wdata,
  output logic [7:0]             io_rdata,
  output logic                   io_err,
  output logic                   intr,
  input  logic                   ack_valid,
  output logic                   ack_ready,
  output logic                   vec_valid,
  input  logic                   vec_ready,
  output logic [VEC_W-1:0]       vec
);
  localparam int UNITS = 2;

  wr_sel_t   [UNITS-1:0] wsel;
  rd_sel_t   [UNITS-1:0] rsel;
  logic      [UNITS-1:0] u_int;
  line_idx_t [UNITS-1:0] u_best;
  logic [UNITS-1:0][7:0] u_base;
  logic [UNITS-1:0][7:0] u_cmd_rd;
  line_vec_t [UNITS-1:0] u_imr;
  line_vec_t [UNITS-1:0] u_trg;
  line_vec_t p_irq, s_irq;
  logic      p_ack, s_ack;
  line_idx_t p_ack_line, s_ack_line;

  pic_port_map #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_map (
    .io_addr (io_addr),
    .io_size (io_size),
    .io_wr   (io_wr),
    .io_rd   (io_rd),
    .wsel    (wsel),
    .rsel    (rsel),
    .acc_err (io_err)
  );

  // secondary interrupt feeds the cascade line of the primary
  assign p_irq = irq[PIC_LINES-1:0] | (line_vec_t'(u_int[1]) << CASC_LINE);
  assign s_irq = irq[2*PIC_LINES-1:PIC_LINES];

  for (genvar g = 0; g < UNITS; g++) begin : g_unit
    localparam line_vec_t UMASK = (g == 0) ? P_TRG_MASK : S_TRG_MASK;
    pic_unit #(.TRG_MASK(UMASK)) u_pic (
      .clk       (clk),
      .rst_n     (rst_n),
      .irq_in    ((g == 0) ? p_irq : s_irq),
      .sel       (wsel[g]),
      .wdata     (io_wdata),
      .ack_en    ((g == 0) ? p_ack : s_ack),
      .ack_line  ((g == 0) ? p_ack_line : s_ack_line),
      .int_out   (u_int[g]),
      .best_line (u_best[g]),
      .base      (u_base[g]),
      .cmd_rdata (u_cmd_rd[g]),
      .imr_o     (u_imr[g]),
      .trg_o     (u_trg[g])
    );
  end

  pic_ack_path #(.VEC_W(VEC_W), .CASC_LINE(CASC_LINE)) u_ack (
    .clk        (clk),
    .rst_n      (rst_n),
    .ack_valid  (ack_valid),
    .ack_ready  (ack_ready),
    .vec_valid  (vec_valid),
    .vec_ready  (vec_ready),
    .vec        (vec),
    .p_int      (u_int[0]),
    .p_line     (u_best[0]),
    .p_base     (VEC_W'(u_base[0])),
    .s_int      (u_int[1]),
    .s_line     (u_best[1]),
    .s_base     (VEC_W'(u_base[1])),
    .p_ack      (p_ack),
    .p_ack_line (p_ack_line),
    .s_ack      (s_ack),
    .s_ack_line (s_ack_line)
  );

  assign intr = u_int[0];

  always_comb begin
    io_rdata = '0;
    for (int g = 0; g < UNITS; g++) begin
      if (rsel[g].cmd_rd) io_rdata = u_cmd_rd[g];
      if (rsel[g].dat_rd) io_rdata = u_imr[g];
      if (rsel[g].trg_rd) io_rdata = u_trg[g];
    end
  end

  AST_BAD_SIZE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    io_err |-> (io_rdata == '0)); // R3
endmodule

// File: tb/casc_irq_ctrl_bench.sv
module casc_irq_ctrl_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic [15:0] irq;
  logic [15:0] io_addr;
  logic [2:0]  io_size;
  logic        io_wr, io_rd;
  logic [7:0]  io_wdata, io_rdata;
  logic        io_err, intr, ack_valid, ack_ready, vec_valid, vec_ready;
  logic [7:0]  vec;

  casc_irq_ctrl u_casc_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq(irq), .io_addr(io_addr), .io_size(io_size),
    .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .io_err(io_err), .intr(intr), .ack_valid(ack_valid), .ack_ready(ack_ready),
    .vec_valid(vec_valid), .vec_ready(vec_ready), .vec(vec)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       wr_err;
  logic [7:0] rd_d;
  logic       rd_e;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic [2:0] sz = 3'd1);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_size = sz; io_wr = 1'b1;
    #1 wr_err = io_err;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [2:0] sz = 3'd1);
    @(negedge clk);
    io_addr = a; io_size = sz; io_rd = 1'b1;
    #1 rd_d = io_rdata; rd_e = io_err;
    io_rd = 1'b0;
  endtask

  task automatic set_irq(input int idx, input logic v);
    @(negedge clk);
    irq[idx] = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ack(input logic [7:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); ack_valid = 1'b1;
    @(negedge clk); ack_valid = 1'b0;
  endtask

  task automatic chk_intr(input logic exp, input string tag);
    @(negedge clk); #1 check(tag, intr, exp);
  endtask

  // acknowledge and command write on the same edge
  task automatic ack_with_cmd(input logic [7:0] exp, input logic [7:0] cmd);
    exp_q.push_back(exp); tag_q.push_back("R13 vector");
    @(negedge clk);
    ack_valid = 1'b1; io_addr = 16'h0020; io_wdata = cmd; io_size = 3'd1; io_wr = 1'b1;
    @(negedge clk);
    ack_valid = 1'b0; io_wr = 1'b0;
  endtask

  // monitor: compares each delivered vector against the scoreboard
  always begin
    @(negedge clk);
    #2;
    if (rst_n && vec_valid && vec_ready) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R11 unexpected vector: actual %0h expected none", vec);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, vec, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog R1-chain: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; irq = '0; io_addr = '0; io_size = 3'd1; io_wr = 1'b0; io_rd = 1'b0;
    io_wdata = '0; ack_valid = 1'b0; vec_ready = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check("R1 intr in reset", intr, 0);
    check("R1 vec_valid in reset", vec_valid, 0);
    check("R1 ack_ready in reset", ack_ready, 1);
    @(negedge clk) rst_n = 1'b1;

    rd(16'h04D0); check("R1 primary trigger reg", rd_d, 8'h00);
    rd(16'h04D1); check("R1 secondary trigger reg", rd_d, 8'h00);
    rd(16'h0021); check("R1 primary mask", rd_d, 8'h00);

    // initialization: base 0x08 / 0x70, cascade word and mode word present
    wr(16'h0020, 8'h11); wr(16'h0021, 8'h08); wr(16'h0021, 8'h04); wr(16'h0021, 8'h01);
    wr(16'h00A0, 8'h11); wr(16'h00A1, 8'h70); wr(16'h00A1, 8'h02); wr(16'h00A1, 8'h01);
    rd(16'h0021); check("R4 mask after init", rd_d, 8'h00);
    wr(16'h0021, 8'h80);
    rd(16'h0021); check("R4 mask write after sequence", rd_d, 8'h80);

    // masked line stays silent
    set_irq(7, 1'b1);
    chk_intr(1'b0, "R7 masked line");
    wr(16'h0021, 8'h00);
    chk_intr(1'b1, "R7 unmasked line");
    ack(8'h0F, "R8 vector line 7");
    wr(16'h0020, 8'h20);
    set_irq(7, 1'b0);

    // trigger-select write masks
    wr(16'h04D0, 8'hFF); rd(16'h04D0); check("R2 primary mask F8", rd_d, 8'hF8);
    wr(16'h04D1, 8'hFF); rd(16'h04D1); check("R2 secondary mask DE", rd_d, 8'hDE);
    wr(16'h04D0, 8'h00); wr(16'h04D1, 8'h00);

    // width rejection
    wr(16'h04D0, 8'hFF, 3'd2); check("R3 write err", wr_err, 1);
    rd(16'h04D0); check("R3 rejected write no effect", rd_d, 8'h00);
    rd(16'h04D1, 3'd4); check("R3 read err", rd_e, 1); check("R3 rejected read data", rd_d, 8'h00);

    // edge mode line 3
    set_irq(3, 1'b1);
    chk_intr(1'b1, "R7 pending edge");
    wr(16'h0020, 8'h0A); rd(16'h0020); check("R5 edge latched", rd_d, 8'h08);
    ack(8'h0B, "R8 vector line 3");
    rd(16'h0020); check("R5 edge cleared by ack", rd_d, 8'h00);
    wr(16'h0020, 8'h0B); rd(16'h0020); check("R8 isr set", rd_d, 8'h08);
    chk_intr(1'b0, "R7 nothing above in-service");
    wr(16'h0020, 8'h20); rd(16'h0020); check("R10 nonspecific eoi", rd_d, 8'h00);
    set_irq(3, 1'b0);

    // nesting and priority
    set_irq(5, 1'b1); idle(1);
    ack(8'h0D, "R8 vector line 5");
    set_irq(6, 1'b1);
    chk_intr(1'b0, "R7 lower priority blocked");
    set_irq(1, 1'b1);
    chk_intr(1'b1, "R7 higher priority passes");
    ack(8'h09, "R8 vector line 1");
    rd(16'h0020); check("R8 nested isr", rd_d, 8'h22);
    wr(16'h0020, 8'h20); rd(16'h0020); check("R10 lowest cleared", rd_d, 8'h20);
    wr(16'h0020, 8'h65); rd(16'h0020); check("R9 specific eoi", rd_d, 8'h00);
    ack(8'h0E, "R8 vector line 6");
    wr(16'h0020, 8'h66);
    set_irq(1, 1'b0); set_irq(5, 1'b0); set_irq(6, 1'b0);

    // level mode line 4
    wr(16'h04D0, 8'h10);
    set_irq(4, 1'b1); idle(1);
    ack(8'h0C, "R8 vector line 4");
    wr(16'h0020, 8'h0A); rd(16'h0020); check("R6 level kept after ack", rd_d, 8'h10);
    set_irq(4, 1'b0); idle(1);
    rd(16'h0020); check("R6 level follows input", rd_d, 8'h00);
    wr(16'h0020, 8'h64); wr(16'h04D0, 8'h00);

    // cascade through primary line 2
    set_irq(10, 1'b1); idle(2);
    chk_intr(1'b1, "R8 cascade raises intr");
    ack(8'h72, "R8 vector secondary line 2");
    wr(16'h00A0, 8'h0B); rd(16'h00A0); check("R8 secondary isr", rd_d, 8'h04);
    wr(16'h0020, 8'h0B); rd(16'h0020); check("R8 primary cascade isr", rd_d, 8'h04);
    wr(16'h00A0, 8'h62); wr(16'h0020, 8'h62);
    set_irq(10, 1'b0);
    rd(16'h0020); check("R9 cascade isr retired", rd_d, 8'h00);

    // spurious acknowledge
    chk_intr(1'b0, "R12 idle before ack");
    ack(8'h0F, "R12 spurious vector");
    rd(16'h0020); check("R12 no isr change", rd_d, 8'h00);

    // back-pressure on the vector
    @(negedge clk) vec_ready = 1'b0;
    set_irq(0, 1'b1); idle(1);
    exp_q.push_back(8'h08); tag_q.push_back("R11 held vector");
    @(negedge clk) ack_valid = 1'b1;
    @(negedge clk) ack_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      #1;
      check("R11 valid held", vec_valid, 1);
      check("R11 ack_ready low", ack_ready, 0);
      check("R11 vector stable", vec, 8'h08);
      @(negedge clk);
    end
    set_irq(1, 1'b1); idle(1);
    @(negedge clk) ack_valid = 1'b1;
    @(negedge clk) ack_valid = 1'b0;
    @(negedge clk) vec_ready = 1'b1;
    idle(1);
    rd(16'h0020); check("R11 second ack ignored", rd_d, 8'h01);
    wr(16'h0020, 8'h20);
    ack(8'h09, "R11 vector after release");
    wr(16'h0020, 8'h20);
    set_irq(0, 1'b0); set_irq(1, 1'b0);

    // same-cycle acknowledge and end-of-interrupt
    set_irq(3, 1'b1); idle(1);
    ack(8'h0B, "R13 setup vector");
    set_irq(1, 1'b1); idle(1);
    ack_with_cmd(8'h09, 8'h63);
    rd(16'h0020); check("R13 specific eoi with ack", rd_d, 8'h02);
    set_irq(0, 1'b1); idle(1);
    ack_with_cmd(8'h08, 8'h20);
    rd(16'h0020); check("R13 nonspecific eoi with ack", rd_d, 8'h01);
    wr(16'h0020, 8'h20);
    set_irq(0, 1'b0); set_irq(1, 1'b0); set_irq(3, 1'b0);

    idle(4);
    check("R11 all vectors delivered", exp_q.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule